// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block keeps a pair of counters driven by a slow tick enable. A down-counter steps toward zero by one on every tick. On the first tick after it has reached zero, it reloads from a reload register, and an event counter steps up by one on that same tick. Zero is therefore held for one whole tick period before the reload. If the reload value is zero, the down-counter stays at zero and the event counter advances on every tick.

The tick comes from one of two sources, chosen by a parameter. The first is a phase accumulator that divides the system clock down to the tick rate; its default tick rate is 20 MHz. The second is an external single-cycle enable input.

All three registers are reset to zero. Each one can be overwritten through a simple write port made of a strobe, a two-bit select and a data word. A write replaces the selected register on the next clock edge, and later ticks continue from the written value.

Top module: `pstk_timer`

## Requirements
- R1: While `rst` is high, the reload register, the down-counter and the event counter all become zero at the next clock edge.
- R2: On a tick, a nonzero down-counter decreases by exactly one.
- R3: On a tick with the down-counter at zero, the down-counter takes the reload value and the event counter increases by one on the same edge. Without a tick, a zero down-counter stays at zero.
- R4: With reload 5 and a start value of 7, fourteen successive ticks give 6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event counter rises by two.
- R5: With reload 0, the down-counter stays at zero once it gets there, and the event counter increases on every tick from then on.
- R6: With `wr_en_i` high, select 0 writes the reload register, select 1 writes the down-counter and select 2 writes the event counter, each taking `wr_data_i` at the next edge. Select 3 changes no register.
- R7: When a write and a tick fall on the same edge, the written register takes the written value. The other registers still see the tick, and a reload on that edge uses the reload value held before the edge.
- R8: The event counter wraps from all ones to zero.
- R9: With no tick and no write, all three registers hold their values.
- R10: With the internal divider, every window of SYS_CLK_HZ consecutive clock cycles contains exactly TICK_HZ ticks. Each tick is a single-cycle pulse when TICK_HZ is at most half of SYS_CLK_HZ.
- R11: A down-counter started below the reload value counts down to zero, holds zero for one tick, and then reloads to the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick_i | input | 1 | External tick enable, used when USE_EXT_TICK=1 |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 reload, 1 down-counter, 2 event counter, 3 none |
| wr_data_i | input | W | Write data |
| reload_o | output | W | Reload register |
| count_o | output | W | Down-counter value |
| events_o | output | W | Event counter value |

## Verification
The bench builds two instances. The first uses USE_EXT_TICK=1 with W=32, so that every tick, every collision between a tick and a write, and the 32-bit wrap of the event counter can be placed on a chosen cycle. The second uses the internal divider with SYS_CLK_HZ=50 and TICK_HZ=20. Those values shrink the divider to a five-cycle pattern, so one whole rate window of 50 cycles fits in a short run and can be checked by counting the decrements of a loaded down-counter.

// File: rtl/pstk_pkg.sv
package pstk_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_EVENTS = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;
endpackage

// File: rtl/pstk_tick_gen.sv
module pstk_tick_gen #(
  parameter bit USE_EXT_TICK = 1'b0,
  parameter int SYS_CLK_HZ   = 50_000_000,
  parameter int TICK_HZ      = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int ACC_W = $clog2(SYS_CLK_HZ + TICK_HZ + 1);
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(SYS_CLK_HZ);

  generate
    if (USE_EXT_TICK) begin : g_ext
      logic clk_rst_unused;
      assign clk_rst_unused = clk ^ rst;
      assign tick_o = ext_tick_i;
    end else begin : g_div
      logic ext_unused;
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] sum;
      logic             tick_q;
      assign ext_unused = ext_tick_i;
      assign sum = acc_q + STEP;

      always_ff @(posedge clk) begin
        if (rst) begin
          acc_q  <= '0;
          tick_q <= 1'b0;
        end else if (sum >= LIMIT) begin
          acc_q  <= sum - LIMIT;
          tick_q <= 1'b1;
        end else begin
          acc_q  <= sum;
          tick_q <= 1'b0;
        end
      end
      assign tick_o = tick_q;
    end
  endgenerate
endmodule

// File: rtl/pstk_prescale_cnt.sv
module pstk_prescale_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         rel_we_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  logic [W-1:0] reload_q;
  logic [W-1:0] count_q;
  logic         at_zero;

  assign at_zero = (count_q == '0);
  assign wrap_o  = tick_i && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (rel_we_i) begin
      reload_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (cnt_we_i) begin
      count_q <= data_i;
    end else if (tick_i) begin
      count_q <= at_zero ? reload_q : count_q - 1'b1;
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
endmodule

// File: rtl/pstk_event_cnt.sv
module pstk_event_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] events_o
);
  logic [W-1:0] events_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      events_q <= '0;
    end else if (we_i) begin
      events_q <= data_i;
    end else if (inc_i) begin
      events_q <= events_q + 1'b1;
    end
  end

  assign events_o = events_q;
endmodule

// File: rtl/pstk_timer.sv
module pstk_timer #(
  parameter int W            = 32,
  parameter bit USE_EXT_TICK = 1'b0,
  parameter int SYS_CLK_HZ   = 50_000_000,
  parameter int TICK_HZ      = 20_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] reload_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] events_o
);
  import pstk_pkg::*;

  sel_e sel;
  logic tick;
  logic wrap;
  logic rel_we, cnt_we, ev_we;

  assign sel    = sel_e'(wr_sel_i);
  assign rel_we = wr_en_i && (sel == SEL_RELOAD);
  assign cnt_we = wr_en_i && (sel == SEL_COUNT);
  assign ev_we  = wr_en_i && (sel == SEL_EVENTS);

  pstk_tick_gen #(
    .USE_EXT_TICK(USE_EXT_TICK),
    .SYS_CLK_HZ  (SYS_CLK_HZ),
    .TICK_HZ     (TICK_HZ)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .ext_tick_i(ext_tick_i),
    .tick_o    (tick)
  );

  pstk_prescale_cnt #(.W(W)) u_pcnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .rel_we_i(rel_we),
    .cnt_we_i(cnt_we),
    .data_i  (wr_data_i),
    .reload_o(reload_o),
    .count_o (count_o),
    .wrap_o  (wrap)
  );

  pstk_event_cnt #(.W(W)) u_ecnt (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (wrap),
    .we_i    (ev_we),
    .data_i  (wr_data_i),
    .events_o(events_o)
  );
endmodule

// File: rtl/pstk_timer_chk.sv
module pstk_timer_chk #(
  parameter int W           = 32,
  parameter bit CHECK_PULSE = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         wr_en_i,
  input logic [1:0]   wr_sel_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] reload_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] events_o
);
  logic cnt_wr, ev_wr, rel_wr;
  assign rel_wr = wr_en_i && (wr_sel_i == 2'd0);
  assign cnt_wr = wr_en_i && (wr_sel_i == 2'd1);
  assign ev_wr  = wr_en_i && (wr_sel_i == 2'd2);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (reload_o == '0 && count_o == '0 && events_o == '0));

  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o != '0 && !cnt_wr) |=> count_o == $past(count_o) - 1'b1);

  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o == '0 && !cnt_wr) |=> count_o == $past(reload_o));

  a_r3_event_inc: assert property (@(posedge clk) disable iff (rst)
    (tick && count_o == '0 && !ev_wr) |=> events_o == $past(events_o) + 1'b1);

  a_r6_count_write: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> count_o == $past(wr_data_i));

  a_r6_reload_write: assert property (@(posedge clk) disable iff (rst)
    rel_wr |=> reload_o == $past(wr_data_i));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en_i) |=> ($stable(count_o) && $stable(events_o) && $stable(reload_o)));

  generate
    if (CHECK_PULSE) begin : g_pulse
      a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind pstk_timer pstk_timer_chk #(
  .W          (W),
  .CHECK_PULSE(!USE_EXT_TICK && (2 * TICK_HZ <= SYS_CLK_HZ))
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .wr_data_i(wr_data_i),
  .reload_o (reload_o),
  .count_o  (count_o),
  .events_o (events_o)
);

// File: tb/sim_pstk_timer.sv
module sim_pstk_timer;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         we = 1'b0;
  logic [1:0]   sel = 2'd3;
  logic [W-1:0] data = '0;
  logic [W-1:0] rel_o, cnt_o, ev_o;

  logic         we1 = 1'b0;
  logic [1:0]   sel1 = 2'd3;
  logic [W-1:0] data1 = '0;
  logic [W-1:0] rel1_o, cnt1_o, ev1_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_rel, m_cnt, m_ev;

  always #10 clk = ~clk;

  pstk_timer #(.W(W), .USE_EXT_TICK(1'b1)) u0 (
    .clk(clk), .rst(rst), .ext_tick_i(tick), .wr_en_i(we), .wr_sel_i(sel),
    .wr_data_i(data), .reload_o(rel_o), .count_o(cnt_o), .events_o(ev_o)
  );

  pstk_timer #(.W(W), .USE_EXT_TICK(1'b0), .SYS_CLK_HZ(50), .TICK_HZ(20)) u1 (
    .clk(clk), .rst(rst), .ext_tick_i(1'b0), .wr_en_i(we1), .wr_sel_i(sel1),
    .wr_data_i(data1), .reload_o(rel1_o), .count_o(cnt1_o), .events_o(ev1_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] nxt_cnt(input logic t, input logic w, input logic [1:0] s,
                                           input logic [W-1:0] d);
    if (w && s == 2'd1) return d;
    if (t) return (m_cnt == '0) ? m_rel : m_cnt - 1'b1;
    return m_cnt;
  endfunction

  function automatic logic [W-1:0] nxt_ev(input logic t, input logic w, input logic [1:0] s,
                                          input logic [W-1:0] d);
    if (w && s == 2'd2) return d;
    if (t && m_cnt == '0) return m_ev + 1'b1;
    return m_ev;
  endfunction

  function automatic logic [W-1:0] nxt_rel(input logic w, input logic [1:0] s,
                                           input logic [W-1:0] d);
    return (w && s == 2'd0) ? d : m_rel;
  endfunction

  // Drive at a falling edge, update the model at the rising edge, return at the next falling edge
  task automatic cyc(input logic t, input logic w, input logic [1:0] s, input logic [W-1:0] d);
    logic [W-1:0] nc, ne, nr;
    tick = t; we = w; sel = s; data = d;
    nc = nxt_cnt(t, w, s, d);
    ne = nxt_ev(t, w, s, d);
    nr = nxt_rel(w, s, d);
    @(posedge clk);
    m_cnt = nc; m_ev = ne; m_rel = nr;
    @(negedge clk);
    tick = 1'b0; we = 1'b0; sel = 2'd3; data = '0;
  endtask

  task automatic chk_all(input string tag);
    chk(tag, cnt_o, m_cnt);
    chk(tag, ev_o, m_ev);
    chk(tag, rel_o, m_rel);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [W-1:0] seq [14];
    seq = '{6, 5, 4, 3, 2, 1, 0, 5, 4, 3, 2, 1, 0, 5};
    void'($urandom(32'd20250611));
    m_rel = '0; m_cnt = '0; m_ev = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 reload", rel_o, '0);
    chk("R1 count", cnt_o, '0);
    chk("R1 events", ev_o, '0);

    // R6: writes through each select
    cyc(1'b0, 1'b1, 2'd0, 32'd5); chk("R6 reload write", rel_o, 32'd5);
    cyc(1'b0, 1'b1, 2'd1, 32'd7); chk("R6 count write", cnt_o, 32'd7);
    cyc(1'b0, 1'b1, 2'd2, 32'd3); chk("R6 events write", ev_o, 32'd3);
    cyc(1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF); chk_all("R6 select 3 ignored");

    // R9: idle hold
    repeat (3) cyc(1'b0, 1'b0, 2'd3, '0);
    chk_all("R9 idle hold");

    // R4 / R2 / R3: reference sequence
    for (int i = 0; i < 14; i++) begin
      cyc(1'b1, 1'b0, 2'd3, '0);
      chk(i == 0 ? "R2 decrement" : (i == 7 ? "R3 reload" : "R4 sequence"), cnt_o, seq[i]);
    end
    chk("R4 events rose by two", ev_o, 32'd5);

    // R3: zero holds without ticks, reloads on the next tick
    cyc(1'b0, 1'b1, 2'd1, '0);
    repeat (3) cyc(1'b0, 1'b0, 2'd3, '0);
    chk("R3 zero held", cnt_o, '0);
    chk("R3 events held", ev_o, 32'd5);
    cyc(1'b1, 1'b0, 2'd3, '0);
    chk("R3 reload on tick", cnt_o, 32'd5);
    chk("R3 event on tick", ev_o, 32'd6);

    // R5: reload of zero sticks
    cyc(1'b0, 1'b1, 2'd0, '0);
    cyc(1'b0, 1'b1, 2'd1, 32'd2);
    cyc(1'b1, 1'b0, 2'd3, '0); chk("R5 step", cnt_o, 32'd1);
    cyc(1'b1, 1'b0, 2'd3, '0); chk("R5 step", cnt_o, 32'd0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0, 2'd3, '0);
      chk("R5 stuck at zero", cnt_o, '0);
      chk("R5 event each tick", ev_o, 32'd7 + i);
    end

    // R11: start below reload
    cyc(1'b0, 1'b1, 2'd0, 32'd9);
    cyc(1'b0, 1'b1, 2'd1, 32'd2);
    cyc(1'b1, 1'b0, 2'd3, '0); chk("R11 down", cnt_o, 32'd1);
    cyc(1'b1, 1'b0, 2'd3, '0); chk("R11 zero", cnt_o, 32'd0);
    cyc(1'b1, 1'b0, 2'd3, '0); chk("R11 reload", cnt_o, 32'd9);

    // R7: collisions between writes and ticks
    cyc(1'b0, 1'b1, 2'd0, 32'd4);
    cyc(1'b0, 1'b1, 2'd1, '0);
    cyc(1'b0, 1'b1, 2'd2, 32'd50);
    cyc(1'b1, 1'b1, 2'd1, 32'd10);
    chk("R7 count write wins", cnt_o, 32'd10);
    chk("R7 events still tick", ev_o, 32'd51);
    cyc(1'b1, 1'b1, 2'd2, 32'd100);
    chk("R7 events write wins", ev_o, 32'd100);
    chk("R7 count still ticks", cnt_o, 32'd9);
    cyc(1'b0, 1'b1, 2'd1, '0);
    cyc(1'b1, 1'b1, 2'd0, 32'd7);
    chk("R7 reload uses old value", cnt_o, 32'd4);
    chk("R7 reload written", rel_o, 32'd7);
    chk("R7 events on reload", ev_o, 32'd101);

    // R8: event wrap
    cyc(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b1, 2'd1, '0);
    cyc(1'b1, 1'b0, 2'd3, '0);
    chk("R8 events wrap", ev_o, '0);

    // R10: internal divider rate over one full window
    we1 = 1'b1; sel1 = 2'd1; data1 = 32'd1000;
    @(posedge clk); @(negedge clk);
    we1 = 1'b0; sel1 = 2'd3;
    chk("R10 load", cnt1_o, 32'd1000);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R10 ticks per window", cnt1_o, 32'd980);

    // R7 mixed: random ticks and writes
    for (int i = 0; i < 3000; i++) begin
      logic t, w;
      logic [1:0] s;
      logic [W-1:0] d;
      t = ($urandom % 2) == 0;
      w = ($urandom % 5) == 0;
      s = 2'($urandom % 4);
      d = (($urandom % 8) == 0) ? W'($urandom) : W'($urandom % 4);
      cyc(t, w, s, d);
      chk_all("R7 random mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule